// File: doc/BRIEF.md
# Converter Output Formatter and Byte Demultiplexer

This block sits between a 14-bit analog-to-digital converter core and the chip's shared output pins. It delays each conversion result through a fixed pipeline that is counted in converter clock cycles. It then places the result on a 14-bit bus in one of two layouts. In full-width layout every result bit is on its own pin. In byte-serial layout an 8-bit receiver reads the result in two halves from the upper pins: the upper half after a converter clock rise, and the lower half after the following fall.

The converter clock arrives as a level. It is sampled by the system clock, and its rising and falling edges are found there. A result word enters the pipeline on each detected rise. The bus is driven only while the output-enable (active low) is asserted and the port-select line indicates data output. In every other state all per-bit drive enables drop, so the pins are released. The one prohibited combination, output enabled while the port is selected for register access, also raises a one-cycle error pulse. Words pass through in straight offset binary with no recoding.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is asserted and directly after it, bus_o is 0, bus_oe_o is 0 and err_o is 0. The latency pipeline starts cleared, so a driven bus shows the value 0 until the first captured word has traveled through it.
- R2: With demux_mode_i = 0 (full-width layout) and the bus driven, bus_o[13:0] equals the presented word bit for bit, with no recoding of the offset-binary value.
- R3: The word on sample_i at the system clock edge where a converter clock rise is detected (adc_clk_i high, previous sample low) is the presented word after the 7th later detected rise. It stays presented until the next rise. Changes of sample_i at any other edge are not captured.
- R4: With demux_mode_i = 1, after a detected rise the bus carries word bits 13:6 on bus bits 13:6, and bus bits 5:0 are 0.
- R5: With demux_mode_i = 1, after a detected fall the bus carries word bits 5:0 on bus bits 13:8, and bus bits 7:0 are 0. The presented word does not change on a fall.
- R6: With oe_n_i = 1, all bits of bus_oe_o are 0 and bus_o is 0 from the next system clock edge onward. The pipeline keeps advancing meanwhile.
- R7: oe_n_i = 0 with port_sel_i = 1 keeps the bus released. err_o is 1 for exactly one cycle after entering that combination. oe_n_i = 1 with port_sel_i = 1 raises no error.
- R8: The bus is driven (bus_oe_o all ones) exactly when oe_n_i = 0 and port_sel_i = 0 at the previous system clock edge. All 14 enables always carry the same value. Changes of demux_mode_i also take effect at the next system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_clk_i | input | 1 | Converter clock level, synchronous to clk |
| sample_i | input | 14 | Conversion result in offset binary |
| demux_mode_i | input | 1 | 0: full-width layout, 1: byte-serial layout |
| oe_n_i | input | 1 | Output enable, active low |
| port_sel_i | input | 1 | 0: pins carry data, 1: pins used for register access |
| bus_o | output | 14 | Output bus value |
| bus_oe_o | output | 14 | Per-bit drive enable, 1 = driven |
| err_o | output | 1 | One-cycle pulse on entering the prohibited enable combination |

## Verification
The hardest situation to reach from the ports is the alignment of an old word with a fresh edge. The value on the pins comes from a rise seven converter cycles back, while the byte half shown depends on whether the latest edge was a rise or a fall. The stimulus sweeps long runs of distinct words through both layouts. It scrambles sample_i on every fall so that a mis-timed capture would show. Each output is compared against a bench history indexed by rise count. The enable combinations are then stepped through while the converter clock keeps running. This shows that releasing and re-driving the bus never disturbs the pipeline contents.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    // Which half of a word the byte-serial layout is presenting
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } byte_phase_e;

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic lvl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        rise_o   = lvl_i & ~st_q.lvl;
        fall_o   = ~lvl_i & st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_lat_pipe.sv
module adc_lat_pipe #(
    parameter int DATA_W = 14,
    parameter int LAT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);

    // LAT words in flight plus the word currently presented
    localparam int NSTG = LAT + 1;

    typedef struct packed {
        logic [NSTG-1:0][DATA_W-1:0] stg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.stg[0] = din_i;
            for (int i = 1; i < NSTG; i++) begin
                st_d.stg[i] = st_q.stg[i-1];
            end
        end
        dout_o = st_q.stg[NSTG-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_bus_fmt.sv
module adc_bus_fmt
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mode_i,
    input  logic              oe_n_i,
    input  logic              port_sel_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] bus_oe_o,
    output logic              err_o
);

    localparam int LO_W = DATA_W - HI_W;

    typedef struct packed {
        byte_phase_e phase;
        logic        demux;
        logic        drive;
        logic        clash;
        logic        err;
    } state_t;

    state_t st_d, st_q;
    logic   clash_now;
    logic [DATA_W-1:0] hi_view, lo_view;

    always_comb begin
        st_d      = st_q;
        clash_now = ~oe_n_i & port_sel_i;

        if (rise_i) begin
            st_d.phase = PH_HIGH;
        end else if (fall_i) begin
            st_d.phase = PH_LOW;
        end

        st_d.demux = mode_i;
        st_d.drive = ~oe_n_i & ~port_sel_i;
        st_d.clash = clash_now;
        st_d.err   = clash_now & ~st_q.clash;

        hi_view = {word_i[DATA_W-1 -: HI_W], {LO_W{1'b0}}};
        lo_view = {word_i[LO_W-1:0], {HI_W{1'b0}}};

        if (!st_q.drive) begin
            bus_o = '0;
        end else if (!st_q.demux) begin
            bus_o = word_i;
        end else if (st_q.phase == PH_LOW) begin
            bus_o = lo_view;
        end else begin
            bus_o = hi_view;
        end

        bus_oe_o = {DATA_W{st_q.drive}};
        err_o    = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HIGH, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
    parameter int DATA_W = 14,
    parameter int HI_W   = 8,
    parameter int LAT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_clk_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              demux_mode_i,
    input  logic              oe_n_i,
    input  logic              port_sel_i,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] bus_oe_o,
    output logic              err_o
);

    logic              adc_rise, adc_fall;
    logic [DATA_W-1:0] shown_word;

    adc_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (adc_clk_i),
        .rise_o (adc_rise),
        .fall_o (adc_fall)
    );

    adc_lat_pipe #(
        .DATA_W (DATA_W),
        .LAT    (LAT)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (adc_rise),
        .din_i   (sample_i),
        .dout_o  (shown_word)
    );

    adc_bus_fmt #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (adc_rise),
        .fall_i     (adc_fall),
        .mode_i     (demux_mode_i),
        .oe_n_i     (oe_n_i),
        .port_sel_i (port_sel_i),
        .word_i     (shown_word),
        .bus_o      (bus_o),
        .bus_oe_o   (bus_oe_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
    parameter int DATA_W = 14,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              demux_mode_i,
    input logic              oe_n_i,
    input logic              port_sel_i,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] bus_oe_o,
    input logic              err_o
);

    localparam int LO_W = DATA_W - HI_W;

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n_i) |-> (bus_oe_o == '0 && bus_o == '0));

    // R7
    port_clash_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!oe_n_i && port_sel_i) |-> (bus_oe_o == '0));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(!oe_n_i && port_sel_i));

    // R8
    drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!oe_n_i && !port_sel_i)) |-> (bus_oe_o == '1));

    // R8
    enable_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == '0) || (bus_oe_o == '1));

    // R4
    demux_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(demux_mode_i) |-> (bus_o[LO_W-1:0] == '0));

endmodule

bind adc_out_fmt adc_out_fmt_chk #(
    .DATA_W (DATA_W),
    .HI_W   (HI_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .demux_mode_i (demux_mode_i),
    .oe_n_i       (oe_n_i),
    .port_sel_i   (port_sel_i),
    .bus_o        (bus_o),
    .bus_oe_o     (bus_oe_o),
    .err_o        (err_o)
);

// File: tb/test_adc_out_fmt.sv
`timescale 1ns/1ps
module test_adc_out_fmt;

    localparam int DW  = 14;
    localparam int LAT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adc_clk_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          demux_mode_i = 1'b0;
    logic          oe_n_i = 1'b1;
    logic          port_sel_i = 1'b0;
    logic [DW-1:0] bus_o;
    logic [DW-1:0] bus_oe_o;
    logic          err_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    int            nrise = 0;
    logic [DW-1:0] hist [0:1023];
    bit            lo_phase = 0;

    always #2.5 clk = ~clk;

    adc_out_fmt i_adc_out_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_clk_i    (adc_clk_i),
        .sample_i     (sample_i),
        .demux_mode_i (demux_mode_i),
        .oe_n_i       (oe_n_i),
        .port_sel_i   (port_sel_i),
        .bus_o        (bus_o),
        .bus_oe_o     (bus_oe_o),
        .err_o        (err_o)
    );

    function automatic logic [DW-1:0] cur_word();
        return (nrise > LAT) ? hist[nrise-LAT] : '0;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] eb,
                       input logic [DW-1:0] eo, input logic ee);
        nchk++;
        if (bus_o !== eb || bus_oe_o !== eo || err_o !== ee) begin
            nerr++;
            $display("FAIL %s: bus=%h oe=%h err=%b expected bus=%h oe=%h err=%b",
                     req, bus_o, bus_oe_o, err_o, eb, eo, ee);
        end
    endtask

    // Expected outputs from the bench model, with no error pulse
    task automatic chk_model(input string req);
        logic [DW-1:0] w, eb;
        bit drv;
        w   = cur_word();
        drv = !oe_n_i && !port_sel_i;
        if (!drv)               eb = '0;
        else if (!demux_mode_i) eb = w;
        else if (lo_phase)      eb = {w[5:0], 8'b0};
        else                    eb = {w[13:6], 6'b0};
        chk(req, eb, drv ? '1 : '0, 1'b0);
    endtask

    // All tasks start and end just after a falling clk edge
    task automatic do_rise(input logic [DW-1:0] s);
        adc_clk_i = 1'b1;
        sample_i  = s;
        @(posedge clk);
        nrise++;
        hist[nrise] = s;
        lo_phase = 0;
        @(negedge clk);
    endtask

    task automatic do_fall(input logic [DW-1:0] junk);
        adc_clk_i = 1'b0;
        sample_i  = junk;
        @(posedge clk);
        lo_phase = 1;
        @(negedge clk);
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 2731 + 5) & 16'h3fff);
    endfunction

    initial begin
        #(100000 * 5);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) idle();
        chk("R1 reset", '0, '0, 1'b0);
        rst_n = 1'b1;
        idle();
        chk("R1 after reset", '0, '0, 1'b0);

        oe_n_i = 1'b0;
        idle();
        chk("R1 cleared pipe", '0, '1, 1'b0);

        // Full-width layout: first LAT words are the cleared pipe (R1), then R3/R2
        for (int i = 1; i <= 40; i++) begin
            logic [DW-1:0] s;
            s = (i == 10) ? 14'h3fff : (i == 11) ? 14'h0000 : pat(i);
            do_rise(s);
            chk_model((nrise <= LAT) ? "R1 zero fill" : "R3 latency R2 full width");
            do_fall(~s);
            chk_model("R3 fall keeps word R2");
        end

        // Byte-serial layout
        demux_mode_i = 1'b1;
        idle();
        chk_model("R8 mode switch R5");
        for (int i = 41; i <= 80; i++) begin
            logic [DW-1:0] s;
            s = (i == 50) ? 14'h3fff : (i == 51) ? 14'h2aaa : pat(i);
            do_rise(s);
            chk_model("R4 high half");
            do_fall(pat(i + 500));
            chk_model("R5 low half");
        end

        // Output released while pipeline runs
        oe_n_i = 1'b1;
        for (int i = 81; i <= 90; i++) begin
            do_rise(pat(i));
            chk_model("R6 released");
            do_fall(pat(i + 700));
            chk_model("R6 released");
        end

        // Released with register-access select: no error
        port_sel_i = 1'b1;
        idle();
        chk("R7 no error when disabled", '0, '0, 1'b0);

        // Prohibited combination
        oe_n_i = 1'b0;
        idle();
        chk("R7 clash pulse", '0, '0, 1'b1);
        do_rise(pat(91));
        chk("R7 clash held", '0, '0, 1'b0);
        do_fall(pat(92));
        chk("R7 clash held", '0, '0, 1'b0);

        // Back to data output
        port_sel_i = 1'b0;
        idle();
        chk_model("R8 re-driven R5");
        demux_mode_i = 1'b0;
        idle();
        chk_model("R8 mode back R2");
        for (int i = 93; i <= 100; i++) begin
            do_rise(pat(i));
            chk_model("R3 after release R2");
            do_fall(pat(i + 900));
            chk_model("R2 hold");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule